// File: doc/BRIEF.md
# GPIO Port Controller with Pad Retention

This block controls one digital I/O port of eight pins through a small register bus. For each pin it turns a three-bit drive-mode code and the pin's output data bit into four pad enables: strong pull-up, weak pull-up, strong pull-down and weak pull-down. It also drives a per-pin input-buffer enable, and it honours separate per-pin input-disable and output-disable bits. Pin levels pass through a two-flop synchroniser into a pin-state register. Per-pin edge detectors set sticky interrupt flags, and these combine into one port interrupt line.

A hold request freezes the pad controls before a low-power period. When the hold is dropped, the wake-cause input selects what happens next. After an interrupt wake, the frozen pad state stays in place until software writes the data register or a configuration register. After a reset wake, every pin floats until that first write.

Top module: `gpio_retention_port`

## Requirements
- R1: During and after reset, all four drive enables and the input enable are 0 on every pin. Every mode field reads 6 (disabled). The data, disable, interrupt-enable, edge and status registers read 0, and the port interrupt is 0.
- R2: The mode field of pin i lies at bits [3i+2:3i] of word address 1. With data bit d, the codes drive: 0 nothing; 1 weak-up if d else strong-down; 2 strong-up if d else weak-down; 3 strong-down only when d=0; 4 strong-up only when d=1; 5 strong-up if d else strong-down; 6 nothing; 7 weak-up if d else weak-down.
- R3: A set bit i in the output-disable register (address 3) clears all four drive enables of pin i, whatever its mode and data.
- R4: A pin's input is inactive when its bit in the input-disable register (address 2) is set, or when its mode is 6. An inactive input has input enable 0, reads 0 in the pin-state register, and sets no interrupt flag.
- R5: The pin-state register (address 4, read-only) shows a pad input change after the third rising clock edge that follows the change, and not after the second.
- R6: The edge code of pin i lies at bits [2i+1:2i] of address 6: 0 selects rising, 1 falling, 2 or 3 both. A selected edge on an active input whose enable bit (address 5) is set makes status bit i (address 7) 1. Pins whose enable bit is clear get no status bit.
- R7: Writing 1s to address 7 clears those status bits. Bits written 0 stay as they are.
- R8: The port interrupt is 1 exactly when some status bit and its enable bit are both 1. Clearing the enable bit drops the interrupt but leaves the status bit pending.
- R9: While the hold request is high, all pad outputs stay at the values they had when the hold began, even if registers are written. The registers themselves still take the writes.
- R10: When the hold drops with the wake cause set to interrupt, the held pad outputs stay until a write to address 0, 1, 2 or 3. Writes to other addresses do not release them. After the releasing write, the pads follow the registers.
- R11: When the hold drops with the wake cause set to reset, all drive enables and input enables are 0 until a write to address 0, 1, 2 or 3. Register contents are kept.
- R12: Addresses 0 to 3 and 5 to 6 read back the value last written, in the low bits of the read data, with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register word address |
| busWrData | input | DATA_W | Register write data |
| busRdData | output | DATA_W | Read data for busAddr, combinational |
| padIn | input | NUM_PINS | Raw pad input levels |
| padStrongUp | output | NUM_PINS | Strong pull-up enables |
| padWeakUp | output | NUM_PINS | Weak pull-up enables |
| padStrongDn | output | NUM_PINS | Strong pull-down enables |
| padWeakDn | output | NUM_PINS | Weak pull-down enables |
| padInEn | output | NUM_PINS | Input buffer enables |
| holdReq | input | 1 | Freeze pad state for low power |
| wakeByIrq | input | 1 | Wake cause: 1 interrupt, 0 reset |
| portIrq | output | 1 | Combined port interrupt request |

## Verification
On every cycle, the assertions check that no pin ever enables a pull-up and a pull-down together. They also check that the pads stay frozen while the hold request is high, and that each wake cause gives the right pad state one cycle after the hold falls. A further check is that the port interrupt only drops after a bus write. The bench scenarios are the only place that shows:
- the full mode table under several data patterns;
- the exact synchroniser latency;
- masking of disabled inputs;
- edge selection per pin;
- write-one-to-clear;
- which register writes end retention.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_OUT    = 0;
  localparam int REG_MODE   = 1;
  localparam int REG_INDIS  = 2;
  localparam int REG_OUTDIS = 3;
  localparam int REG_STATE  = 4;
  localparam int REG_INTEN  = 5;
  localparam int REG_EDGE   = 6;
  localparam int REG_STAT   = 7;

  localparam logic [2:0] MODE_OFF = 3'd6;

  typedef enum logic [1:0] {
    PAD_LIVE,
    PAD_HELD,
    PAD_HIZ
  } padSel_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_HOLD,
    ST_KEEP,
    ST_FLOAT
  } holdState_e;

  typedef struct packed {
    logic    wrOut;
    logic    wrMode;
    logic    wrInDis;
    logic    wrOutDis;
    logic    wrIntEn;
    logic    wrEdge;
    logic    wrClr;
    logic    capture;
    padSel_e padSel;
  } ctlStrobes_t;

  // Returns {strongUp, weakUp, strongDn, weakDn} for a mode code and data bit.
  function automatic logic [3:0] driveDecode(input logic [2:0] mode, input logic d);
    logic [3:0] r;
    case (mode)
      3'd1:    r = d ? 4'b0100 : 4'b0010;
      3'd2:    r = d ? 4'b1000 : 4'b0001;
      3'd3:    r = d ? 4'b0000 : 4'b0010;
      3'd4:    r = d ? 4'b1000 : 4'b0000;
      3'd5:    r = d ? 4'b1000 : 4'b0010;
      3'd7:    r = d ? 4'b0100 : 4'b0001;
      default: r = 4'b0000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_retention_ctrl.sv
module gpio_retention_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              holdReq,
  input  logic              wakeByIrq,
  output ctlStrobes_t       strobes
);

  holdState_e stateQ, stateD;
  logic cfgWrite;

  always_comb begin
    strobes          = '0;
    strobes.wrOut    = busWrEn && (busAddr == ADDR_W'(REG_OUT));
    strobes.wrMode   = busWrEn && (busAddr == ADDR_W'(REG_MODE));
    strobes.wrInDis  = busWrEn && (busAddr == ADDR_W'(REG_INDIS));
    strobes.wrOutDis = busWrEn && (busAddr == ADDR_W'(REG_OUTDIS));
    strobes.wrIntEn  = busWrEn && (busAddr == ADDR_W'(REG_INTEN));
    strobes.wrEdge   = busWrEn && (busAddr == ADDR_W'(REG_EDGE));
    strobes.wrClr    = busWrEn && (busAddr == ADDR_W'(REG_STAT));
    strobes.capture  = holdReq && (stateQ != ST_HOLD);
    case (stateQ)
      ST_RUN:   strobes.padSel = PAD_LIVE;
      ST_FLOAT: strobes.padSel = PAD_HIZ;
      default:  strobes.padSel = PAD_HELD;
    endcase
  end

  assign cfgWrite = strobes.wrOut | strobes.wrMode | strobes.wrInDis | strobes.wrOutDis;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_RUN:  if (holdReq) stateD = ST_HOLD;
      ST_HOLD: if (!holdReq) stateD = wakeByIrq ? ST_KEEP : ST_FLOAT;
      default: begin
        if (holdReq)       stateD = ST_HOLD;
        else if (cfgWrite) stateD = ST_RUN;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/gpio_retention_dp.sv
module gpio_retention_dp
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padStrongUp,
  output logic [NUM_PINS-1:0] padWeakUp,
  output logic [NUM_PINS-1:0] padStrongDn,
  output logic [NUM_PINS-1:0] padWeakDn,
  output logic [NUM_PINS-1:0] padInEn,
  output logic                portIrq
);

  localparam int MODE_W = 3 * NUM_PINS;
  localparam int EDGE_W = 2 * NUM_PINS;

  logic [NUM_PINS-1:0] outQ, inDisQ, outDisQ, intEnQ, intStatQ;
  logic [NUM_PINS-1:0] syncA, syncB, pinStateQ, prevStateQ;
  logic [MODE_W-1:0]   modeQ;
  logic [EDGE_W-1:0]   edgeQ;

  logic [NUM_PINS-1:0] liveSu, liveWu, liveSd, liveWd, inAct, edgeHit;
  logic [NUM_PINS-1:0] heldSu, heldWu, heldSd, heldWd, heldInEn;
  logic [NUM_PINS-1:0] clrMask;

  // Configuration and data registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ    <= '0;
      modeQ   <= {NUM_PINS{MODE_OFF}};
      inDisQ  <= '0;
      outDisQ <= '0;
      intEnQ  <= '0;
      edgeQ   <= '0;
    end else begin
      if (strobes.wrOut)    outQ    <= busWrData[NUM_PINS-1:0];
      if (strobes.wrMode)   modeQ   <= busWrData[MODE_W-1:0];
      if (strobes.wrInDis)  inDisQ  <= busWrData[NUM_PINS-1:0];
      if (strobes.wrOutDis) outDisQ <= busWrData[NUM_PINS-1:0];
      if (strobes.wrIntEn)  intEnQ  <= busWrData[NUM_PINS-1:0];
      if (strobes.wrEdge)   edgeQ   <= busWrData[EDGE_W-1:0];
    end
  end

  generate
    if (DATA_W > MODE_W) begin : g_sink
      logic unusedUpper;
      assign unusedUpper = ^busWrData[DATA_W-1:MODE_W];
    end
  endgenerate

  // Per-pin drive decode, input activity and edge selection
  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [2:0] pinMode;
      logic [1:0] pinEdge;
      logic [3:0] dec;
      logic       rise, fall;
      assign pinMode   = modeQ[3*i +: 3];
      assign pinEdge   = edgeQ[2*i +: 2];
      assign dec       = driveDecode(pinMode, outQ[i]);
      assign liveSu[i] = dec[3] & ~outDisQ[i];
      assign liveWu[i] = dec[2] & ~outDisQ[i];
      assign liveSd[i] = dec[1] & ~outDisQ[i];
      assign liveWd[i] = dec[0] & ~outDisQ[i];
      assign inAct[i]  = ~inDisQ[i] & (pinMode != MODE_OFF);
      assign rise      = pinStateQ[i] & ~prevStateQ[i];
      assign fall      = ~pinStateQ[i] & prevStateQ[i];
      assign edgeHit[i] = (pinEdge == 2'd0) ? rise :
                          (pinEdge == 2'd1) ? fall : (rise | fall);
    end
  endgenerate

  // Input synchroniser, pin state and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA      <= '0;
      syncB      <= '0;
      pinStateQ  <= '0;
      prevStateQ <= '0;
    end else begin
      syncA      <= padIn;
      syncB      <= syncA;
      pinStateQ  <= syncB & inAct;
      prevStateQ <= pinStateQ;
    end
  end

  // Sticky interrupt status, write-one-to-clear, set wins over clear
  assign clrMask = strobes.wrClr ? busWrData[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intStatQ <= '0;
    else       intStatQ <= (intStatQ & ~clrMask) | (edgeHit & intEnQ & inAct);
  end

  assign portIrq = |(intStatQ & intEnQ);

  // Retention capture of whatever the pads currently show
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldSu   <= '0;
      heldWu   <= '0;
      heldSd   <= '0;
      heldWd   <= '0;
      heldInEn <= '0;
    end else if (strobes.capture) begin
      heldSu   <= padStrongUp;
      heldWu   <= padWeakUp;
      heldSd   <= padStrongDn;
      heldWd   <= padWeakDn;
      heldInEn <= padInEn;
    end
  end

  always_comb begin
    case (strobes.padSel)
      PAD_LIVE: begin
        padStrongUp = liveSu;
        padWeakUp   = liveWu;
        padStrongDn = liveSd;
        padWeakDn   = liveWd;
        padInEn     = inAct;
      end
      PAD_HELD: begin
        padStrongUp = heldSu;
        padWeakUp   = heldWu;
        padStrongDn = heldSd;
        padWeakDn   = heldWd;
        padInEn     = heldInEn;
      end
      default: begin
        padStrongUp = '0;
        padWeakUp   = '0;
        padStrongDn = '0;
        padWeakDn   = '0;
        padInEn     = '0;
      end
    endcase
  end

  // Register read mux
  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_W'(REG_OUT):    busRdData[NUM_PINS-1:0] = outQ;
      ADDR_W'(REG_MODE):   busRdData[MODE_W-1:0]   = modeQ;
      ADDR_W'(REG_INDIS):  busRdData[NUM_PINS-1:0] = inDisQ;
      ADDR_W'(REG_OUTDIS): busRdData[NUM_PINS-1:0] = outDisQ;
      ADDR_W'(REG_STATE):  busRdData[NUM_PINS-1:0] = pinStateQ;
      ADDR_W'(REG_INTEN):  busRdData[NUM_PINS-1:0] = intEnQ;
      ADDR_W'(REG_EDGE):   busRdData[EDGE_W-1:0]   = edgeQ;
      ADDR_W'(REG_STAT):   busRdData[NUM_PINS-1:0] = intStatQ;
      default:             busRdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_retention_port.sv
module gpio_retention_port
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padStrongUp,
  output logic [NUM_PINS-1:0] padWeakUp,
  output logic [NUM_PINS-1:0] padStrongDn,
  output logic [NUM_PINS-1:0] padWeakDn,
  output logic [NUM_PINS-1:0] padInEn,
  input  logic                holdReq,
  input  logic                wakeByIrq,
  output logic                portIrq
);

  ctlStrobes_t strobes;

  gpio_retention_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .holdReq   (holdReq),
    .wakeByIrq (wakeByIrq),
    .strobes   (strobes)
  );

  gpio_retention_dp #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .padIn       (padIn),
    .padStrongUp (padStrongUp),
    .padWeakUp   (padWeakUp),
    .padStrongDn (padStrongDn),
    .padWeakDn   (padWeakDn),
    .padInEn     (padInEn),
    .portIrq     (portIrq)
  );

endmodule

// File: rtl/gpio_retention_chk.sv
module gpio_retention_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic                holdReq,
  input logic                wakeByIrq,
  input logic [NUM_PINS-1:0] padStrongUp,
  input logic [NUM_PINS-1:0] padWeakUp,
  input logic [NUM_PINS-1:0] padStrongDn,
  input logic [NUM_PINS-1:0] padWeakDn,
  input logic [NUM_PINS-1:0] padInEn,
  input logic                portIrq
);

  logic pastValid;
  logic [5*NUM_PINS-1:0] padAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  assign padAll = {padStrongUp, padWeakUp, padStrongDn, padWeakDn, padInEn};

  // R2
  no_crowbar_chk: assert property (@(posedge clk) disable iff (!rstN)
    (((padStrongUp | padWeakUp) & (padStrongDn | padWeakDn)) == '0) &&
    ((padStrongUp & padWeakUp) == '0) && ((padStrongDn & padWeakDn) == '0));

  // R9
  hold_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && holdReq && $past(holdReq) |-> $stable(padAll));

  // R10
  irq_wake_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $fell(holdReq) && wakeByIrq |=> $stable(padAll));

  // R11
  reset_wake_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $fell(holdReq) && !wakeByIrq |=> (padAll == '0));

  // R7
  irq_drop_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    pastValid && $fell(portIrq) |-> $past(busWrEn));

endmodule

bind gpio_retention_port gpio_retention_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/gpio_retention_port_bench.sv
`timescale 1ns/1ps
module gpio_retention_port_bench;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [N-1:0] padIn = '0;
  logic [N-1:0] padStrongUp, padWeakUp, padStrongDn, padWeakDn, padInEn;
  logic        holdReq = 1'b0;
  logic        wakeByIrq = 1'b0;
  logic        portIrq;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  typedef struct {
    int          sel;
    logic [31:0] expVal;
    string       tag;
  } item_t;

  item_t sb[$];

  always #2.5 clk = ~clk;

  gpio_retention_port u_gpio_retention_port (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .padIn(padIn),
    .padStrongUp(padStrongUp), .padWeakUp(padWeakUp),
    .padStrongDn(padStrongDn), .padWeakDn(padWeakDn), .padInEn(padInEn),
    .holdReq(holdReq), .wakeByIrq(wakeByIrq), .portIrq(portIrq)
  );

  // Expected pad vector {su, wu, sd, wd}, built from the mode table.
  function automatic logic [31:0] expPads(logic [23:0] mode, logic [7:0] dout, logic [7:0] odis);
    logic [7:0] su, wu, sd, wd;
    su = '0; wu = '0; sd = '0; wd = '0;
    for (int i = 0; i < N; i++) begin
      logic [2:0] m;
      logic hi;
      m = mode[3*i +: 3];
      hi = dout[i];
      if (!odis[i]) begin
        su[i] = hi  && (m == 3'd2 || m == 3'd4 || m == 3'd5);
        wu[i] = hi  && (m == 3'd1 || m == 3'd7);
        sd[i] = !hi && (m == 3'd1 || m == 3'd3 || m == 3'd5);
        wd[i] = !hi && (m == 3'd2 || m == 3'd7);
      end
    end
    return {su, wu, sd, wd};
  endfunction

  function automatic logic [23:0] allMode(logic [2:0] m);
    logic [23:0] r;
    for (int i = 0; i < N; i++) r[3*i +: 3] = m;
    return r;
  endfunction

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.sel)
        0:       act = busRdData;
        1:       act = {padStrongUp, padWeakUp, padStrongDn, padWeakDn};
        2:       act = {24'd0, padInEn};
        default: act = {31'd0, portIrq};
      endcase
      testCount++;
      if (act !== it.expVal) begin
        failCount++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.expVal);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    busWrEn = 1'b1;
    busAddr = a;
    busWrData = d;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic checkOut(input int sel, input logic [3:0] a, input logic [31:0] e, input string tag);
    busAddr = a;
    sb.push_back('{sel, e, tag});
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    logic [23:0] mode;
    logic [23:0] m5;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(1);

    // R1 reset state
    checkOut(0, 4'd1, {8'd0, allMode(3'd6)}, "R1 mode reset");
    checkOut(0, 4'd0, 32'd0, "R1 data reset");
    checkOut(0, 4'd7, 32'd0, "R1 status reset");
    checkOut(1, 4'd0, 32'd0, "R1 drive reset");
    checkOut(2, 4'd0, 32'd0, "R1 input enable reset");
    checkOut(3, 4'd0, 32'd0, "R1 irq reset");

    // R2 mode table: pin i uses code i
    for (int i = 0; i < N; i++) mode[3*i +: 3] = 3'(i);
    wr(4'd1, {8'd0, mode});
    wr(4'd0, 32'h00);
    checkOut(1, 4'd0, expPads(mode, 8'h00, 8'h00), "R2 data 00");
    checkOut(2, 4'd0, 32'hBF, "R4 mode off input");
    wr(4'd0, 32'hFF);
    checkOut(1, 4'd0, expPads(mode, 8'hFF, 8'h00), "R2 data FF");
    wr(4'd0, 32'hA5);
    checkOut(1, 4'd0, expPads(mode, 8'hA5, 8'h00), "R2 data A5");

    // R3 output disable
    wr(4'd3, 32'h0F);
    checkOut(1, 4'd0, expPads(mode, 8'hA5, 8'h0F), "R3 outdis 0F");
    checkOut(0, 4'd3, 32'h0F, "R12 outdis readback");
    wr(4'd3, 32'h00);
    checkOut(0, 4'd1, {8'd0, mode}, "R12 mode readback");
    checkOut(0, 4'd0, 32'hA5, "R12 data readback");

    // R5 synchroniser latency
    wr(4'd1, 32'd0);
    padIn = 8'h3C;
    idle(2);
    checkOut(0, 4'd4, 32'h00, "R5 not yet after two edges");
    checkOut(0, 4'd4, 32'h3C, "R5 after three edges");

    // R4 input disable
    wr(4'd2, 32'h0C);
    checkOut(2, 4'd0, 32'hF3, "R4 input enable");
    checkOut(0, 4'd4, 32'h30, "R4 masked state");
    wr(4'd6, 32'hA0);
    wr(4'd5, 32'h0C);
    padIn = 8'h30; idle(5);
    padIn = 8'h3C; idle(5);
    checkOut(0, 4'd7, 32'h00, "R4 no status when disabled");
    checkOut(3, 4'd0, 32'd0, "R4 no irq when disabled");
    padIn = 8'h30; idle(5);
    wr(4'd2, 32'h00);
    wr(4'd5, 32'h00);
    idle(5);
    checkOut(0, 4'd6, 32'hA0, "R12 edge readback");

    // R6 edge selection: pin0 rise, pin1 fall, pin2 both, pin3 not enabled
    wr(4'd6, 32'h24);
    wr(4'd5, 32'h07);
    checkOut(0, 4'd5, 32'h07, "R12 enable readback");
    padIn = 8'h3F; idle(6);
    checkOut(0, 4'd7, 32'h05, "R6 rising edges");
    checkOut(3, 4'd0, 32'd1, "R8 irq set");
    wr(4'd7, 32'h01);
    checkOut(0, 4'd7, 32'h04, "R7 clear pin0 only");
    padIn = 8'h38; idle(6);
    checkOut(0, 4'd7, 32'h06, "R6 falling edges");
    wr(4'd7, 32'h06);
    checkOut(0, 4'd7, 32'h00, "R7 clear all");
    checkOut(3, 4'd0, 32'd0, "R7 irq low after clear");

    // R8 enable gating of the port request
    padIn = 8'h39; idle(6);
    checkOut(3, 4'd0, 32'd1, "R8 irq pin0");
    wr(4'd5, 32'h00);
    checkOut(3, 4'd0, 32'd0, "R8 irq gated");
    checkOut(0, 4'd7, 32'h01, "R8 status still pending");
    wr(4'd5, 32'h01);
    checkOut(3, 4'd0, 32'd1, "R8 irq back");
    wr(4'd7, 32'h01);
    wr(4'd5, 32'h00);

    // R9 hold freezes pads
    m5 = allMode(3'd5);
    wr(4'd1, {8'd0, m5});
    wr(4'd0, 32'h55);
    checkOut(1, 4'd0, expPads(m5, 8'h55, 8'h00), "R9 before hold");
    holdReq = 1'b1;
    idle(1);
    wr(4'd0, 32'hAA);
    wr(4'd1, 32'd0);
    wr(4'd2, 32'hFF);
    checkOut(1, 4'd0, expPads(m5, 8'h55, 8'h00), "R9 drive frozen");
    checkOut(2, 4'd0, 32'hFF, "R9 input enable frozen");
    checkOut(0, 4'd0, 32'hAA, "R9 register took write");

    // R10 wake by interrupt keeps state until config/data write
    wakeByIrq = 1'b1;
    holdReq = 1'b0;
    idle(2);
    checkOut(1, 4'd0, expPads(m5, 8'h55, 8'h00), "R10 kept after wake");
    wr(4'd5, 32'h02);
    checkOut(1, 4'd0, expPads(m5, 8'h55, 8'h00), "R10 enable write keeps");
    wr(4'd1, {8'd0, m5});
    checkOut(1, 4'd0, expPads(m5, 8'hAA, 8'h00), "R10 released by mode write");
    checkOut(2, 4'd0, 32'h00, "R10 live input enable");
    wr(4'd5, 32'h00);
    wr(4'd2, 32'h00);

    // R11 wake by reset floats the pins
    wr(4'd0, 32'h33);
    checkOut(1, 4'd0, expPads(m5, 8'h33, 8'h00), "R11 before hold");
    wakeByIrq = 1'b0;
    holdReq = 1'b1;
    idle(1);
    holdReq = 1'b0;
    idle(2);
    checkOut(1, 4'd0, 32'd0, "R11 drive floats");
    checkOut(2, 4'd0, 32'd0, "R11 input enable off");
    checkOut(0, 4'd0, 32'h33, "R11 register kept");
    wr(4'd0, 32'h33);
    checkOut(1, 4'd0, expPads(m5, 8'h33, 8'h00), "R11 live after write");
    checkOut(2, 4'd0, 32'hFF, "R11 input live");

    idle(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule